// File: doc/BRIEF.md
# Remote Terminal Command Legality Responder

This block decides how a serial-bus remote terminal answers each command word it has decoded. When a command arrives, its broadcast flag, direction bit, subaddress and word-count/mode field are captured. They are driven out as a 12-bit address into an external one-bit legality table. The address then stays unchanged for the whole message.

A fixed number of clock cycles after the command strobe, the block samples the table output and an active-low subsystem busy input, both once. From those two samples and the terminal address it builds the status word, with its Message Error and Busy bits. It also tells the transmit sequencer how many data words follow the status word. A receive command always passes its data through to the subsystem. A transmit command that is refused or busy sends the status word alone.

The sampled results are held until the message ends. A new command word abandons the current message and starts the sequence again. Set `SAMPLE_DELAY` so that the table's access time fits between the command strobe and the sample point. When no legality table is fitted, tie `legalIn` high and every command is accepted.

Top module: `cmd_legality_responder`

## Requirements
- R1: `tableAddr` equals {broadcast (bit 11), T/R (bit 10), subaddress (bits 9:5), word count/mode (bits 4:0)}, captured at the clock edge where `cmdValid` is high. It stays unchanged until the next `cmdValid`.
- R2: `legalIn`, `busyInN` and `rtAddr` are sampled at exactly one edge, `SAMPLE_DELAY` clock edges after the `cmdValid` edge. `respValid` is high for the one cycle following that edge, and values on these inputs at any other edge have no effect.
- R3: A sampled `legalIn` of 0 sets `statusWord[10]` (Message Error, bit time 9). A sampled 1 clears it, so a table tied high makes every command legal.
- R4: A sampled `busyInN` of 0 sets `statusWord[3]` (Busy, bit time 16). A sampled 1 clears it.
- R5: After sampling, `statusWord[15:11]` equals the sampled `rtAddr`, and every status bit other than bits 15:11, 10 and 3 is 0.
- R6: For a transmit command (T/R = 1) sampled legal and not busy, `txWordCount` equals the word count field. A field of 0 gives 32.
- R7: For a transmit command sampled illegal or busy, `txWordCount` is 0, so only the status word is sent.
- R8: For a receive command (T/R = 0), `rxPass` is 1 after sampling whatever the legality and busy samples were, and `txWordCount` is 0.
- R9: Sampled results hold on the outputs until a `msgEnd` pulse. After the pulse, `statusWord`, `txWordCount` and `rxPass` are 0. A `msgEnd` before the sample point cancels the sample, and `respValid` stays 0.
- R10: A `cmdValid` at any time clears the held results and restarts the sample delay from that edge. `cmdValid` takes priority over `msgEnd`.
- R11: After reset, `tableAddr`, `statusWord`, `txWordCount`, `rxPass` and `respValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | One-cycle strobe, a command word has been decoded |
| cmdBcast | input | 1 | Broadcast flag of the command |
| cmdTx | input | 1 | T/R bit, 1 = transmit |
| cmdSubaddr | input | 5 | Subaddress/mode field |
| cmdCount | input | 5 | Word count or mode code field |
| msgEnd | input | 1 | One-cycle strobe, current message finished |
| legalIn | input | 1 | Legality table output, 0 = illegal |
| busyInN | input | 1 | Subsystem busy, active low |
| rtAddr | input | 5 | Terminal address placed in the status word |
| tableAddr | output | 12 | Address to the legality table |
| respValid | output | 1 | One-cycle pulse, results have just been sampled |
| statusWord | output | 16 | Status word, bit 15 sent first |
| txWordCount | output | 6 | Data words to send after the status word |
| rxPass | output | 1 | Receive data is passed to the subsystem |

## Verification
A wrong sample counter shows up as `respValid` rising one or more cycles early or late. It also makes the block pick up a legality or busy value that the bench changes on the neighbouring edges, and the status bits go wrong in the same cycle. A wrong held flag or direction register shows on `txWordCount` or `rxPass` in the cycle after the sample edge. It also shows as outputs that survive or vanish across the cycles before `msgEnd`. An address capture error is visible on `tableAddr` one cycle after the command strobe, long before any sample is taken.

// File: rtl/clr_pkg.sv
package clr_pkg;
  localparam int SA_W = 5;
  localparam int WC_W = 5;
  localparam int ADDR_W = 2 + SA_W + WC_W;
  localparam int RTA_W = 5;
  localparam int STATUS_W = 16;
  localparam int CNT_OUT_W = WC_W + 1;

  // status word bit time n (n = 4..19) maps to vector index 19 - n
  function automatic int statusIndex(input int bitTime);
    return 19 - bitTime;
  endfunction

  localparam int ME_POS = statusIndex(9);
  localparam int BUSY_POS = statusIndex(16);
  localparam int RTA_TOP = statusIndex(4);

  typedef struct packed {
    logic loadCmd;
    logic sampleNow;
    logic clearHeld;
  } ctrl_strobe_t;
endpackage

// File: rtl/clr_control.sv
module clr_control
  import clr_pkg::*;
#(
  parameter int SAMPLE_DELAY = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         msgEnd,
  output ctrl_strobe_t strobe,
  output logic         respValid
);
  localparam int CNT_W = (SAMPLE_DELAY > 1) ? $clog2(SAMPLE_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SAMPLE_DELAY - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} state_t;

  state_t state;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    strobe.loadCmd   = cmdValid;
    strobe.sampleNow = (state == ST_WAIT) && (waitCnt == '0) && !cmdValid && !msgEnd;
    strobe.clearHeld = msgEnd && !cmdValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      respValid <= 1'b0;
    end else begin
      respValid <= strobe.sampleNow;
      if (cmdValid) begin
        state   <= ST_WAIT;
        waitCnt <= CNT_LOAD;
      end else begin
        unique case (state)
          ST_WAIT: begin
            if (msgEnd) state <= ST_IDLE;
            else if (waitCnt == '0) state <= ST_HOLD;
            else waitCnt <= waitCnt - 1'b1;
          end
          ST_HOLD: if (msgEnd) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/clr_datapath.sv
module clr_datapath
  import clr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         strobe,
  input  logic                 cmdBcast,
  input  logic                 cmdTx,
  input  logic [SA_W-1:0]      cmdSubaddr,
  input  logic [WC_W-1:0]      cmdCount,
  input  logic                 legalIn,
  input  logic                 busyInN,
  input  logic [RTA_W-1:0]     rtAddr,
  output logic [ADDR_W-1:0]    tableAddr,
  output logic [STATUS_W-1:0]  statusWord,
  output logic [CNT_OUT_W-1:0] txWordCount,
  output logic                 rxPass
);
  localparam logic [CNT_OUT_W-1:0] FULL_COUNT = CNT_OUT_W'(2 ** WC_W);

  logic [ADDR_W-1:0] addrReg;
  logic              txReg;
  logic [WC_W-1:0]   countReg;
  logic              msgErrReg;
  logic              busyReg;
  logic [RTA_W-1:0]  rtaReg;
  logic              heldValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      txReg    <= 1'b0;
      countReg <= '0;
    end else if (strobe.loadCmd) begin
      addrReg  <= {cmdBcast, cmdTx, cmdSubaddr, cmdCount};
      txReg    <= cmdTx;
      countReg <= cmdCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgErrReg <= 1'b0;
      busyReg   <= 1'b0;
      rtaReg    <= '0;
      heldValid <= 1'b0;
    end else if (strobe.loadCmd || strobe.clearHeld) begin
      msgErrReg <= 1'b0;
      busyReg   <= 1'b0;
      rtaReg    <= '0;
      heldValid <= 1'b0;
    end else if (strobe.sampleNow) begin
      msgErrReg <= !legalIn;
      busyReg   <= !busyInN;
      rtaReg    <= rtAddr;
      heldValid <= 1'b1;
    end
  end

  assign tableAddr = addrReg;

  always_comb begin
    statusWord = '0;
    statusWord[RTA_TOP -: RTA_W] = rtaReg;
    statusWord[ME_POS]   = msgErrReg;
    statusWord[BUSY_POS] = busyReg;
  end

  always_comb begin
    txWordCount = '0;
    if (heldValid && txReg && !msgErrReg && !busyReg)
      txWordCount = (countReg == '0) ? FULL_COUNT : CNT_OUT_W'(countReg);
  end

  assign rxPass = heldValid && !txReg;
endmodule

// File: rtl/cmd_legality_responder.sv
module cmd_legality_responder
  import clr_pkg::*;
#(
  parameter int SAMPLE_DELAY = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdBcast,
  input  logic                 cmdTx,
  input  logic [SA_W-1:0]      cmdSubaddr,
  input  logic [WC_W-1:0]      cmdCount,
  input  logic                 msgEnd,
  input  logic                 legalIn,
  input  logic                 busyInN,
  input  logic [RTA_W-1:0]     rtAddr,
  output logic [ADDR_W-1:0]    tableAddr,
  output logic                 respValid,
  output logic [STATUS_W-1:0]  statusWord,
  output logic [CNT_OUT_W-1:0] txWordCount,
  output logic                 rxPass
);
  ctrl_strobe_t strobe;

  clr_control #(.SAMPLE_DELAY(SAMPLE_DELAY)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .msgEnd    (msgEnd),
    .strobe    (strobe),
    .respValid (respValid)
  );

  clr_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdBcast    (cmdBcast),
    .cmdTx       (cmdTx),
    .cmdSubaddr  (cmdSubaddr),
    .cmdCount    (cmdCount),
    .legalIn     (legalIn),
    .busyInN     (busyInN),
    .rtAddr      (rtAddr),
    .tableAddr   (tableAddr),
    .statusWord  (statusWord),
    .txWordCount (txWordCount),
    .rxPass      (rxPass)
  );
endmodule

// File: rtl/clr_checker.sv
module clr_checker
  import clr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic                 msgEnd,
  input logic                 legalIn,
  input logic                 busyInN,
  input logic [ADDR_W-1:0]    tableAddr,
  input logic                 respValid,
  input logic [STATUS_W-1:0]  statusWord,
  input logic [CNT_OUT_W-1:0] txWordCount,
  input logic                 rxPass
);
  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(tableAddr));

  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_msgerr_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respValid) |-> (statusWord[ME_POS] == !$past(legalIn)));

  assert_busy_sample_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respValid) |-> (statusWord[BUSY_POS] == !$past(busyInN)));

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    txWordCount <= CNT_OUT_W'(2 ** WC_W));

  assert_refused_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[ME_POS] || statusWord[BUSY_POS]) |-> (txWordCount == '0));

  assert_rx_no_tx_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxPass |-> (txWordCount == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !msgEnd) |=> ($stable(statusWord) || respValid));

  assert_clear_on_cmd_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (statusWord == '0 && !rxPass && txWordCount == '0));
endmodule

bind cmd_legality_responder clr_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .msgEnd      (msgEnd),
  .legalIn     (legalIn),
  .busyInN     (busyInN),
  .tableAddr   (tableAddr),
  .respValid   (respValid),
  .statusWord  (statusWord),
  .txWordCount (txWordCount),
  .rxPass      (rxPass)
);

// File: tb/cmd_legality_responder_tb.sv
module cmd_legality_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY = 8;
  localparam int NVEC = 8;

  typedef struct packed {
    logic       bc;
    logic       tx;
    logic [4:0] sa;
    logic [4:0] wc;
    logic       legal;
    logic       busyN;
    logic [4:0] rta;
    logic       expMe;
    logic       expBusy;
    logic [5:0] expCnt;
    logic       expRx;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 5'd3,  5'd4,  1'b1, 1'b1, 5'h0A, 1'b0, 1'b0, 6'd4,  1'b0},
    '{1'b0, 1'b1, 5'd1,  5'd0,  1'b1, 1'b1, 5'h1F, 1'b0, 1'b0, 6'd32, 1'b0},
    '{1'b0, 1'b1, 5'd7,  5'd9,  1'b0, 1'b1, 5'h03, 1'b1, 1'b0, 6'd0,  1'b0},
    '{1'b0, 1'b1, 5'd2,  5'd31, 1'b1, 1'b0, 5'h11, 1'b0, 1'b1, 6'd0,  1'b0},
    '{1'b0, 1'b0, 5'd5,  5'd6,  1'b0, 1'b0, 5'h07, 1'b1, 1'b1, 6'd0,  1'b1},
    '{1'b1, 1'b0, 5'd30, 5'd17, 1'b1, 1'b1, 5'h15, 1'b0, 1'b0, 6'd0,  1'b1},
    '{1'b0, 1'b0, 5'd0,  5'd0,  1'b1, 1'b0, 5'h00, 1'b0, 1'b1, 6'd0,  1'b1},
    '{1'b1, 1'b1, 5'd31, 5'd31, 1'b0, 1'b0, 5'h1E, 1'b1, 1'b1, 6'd0,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdBcast = 1'b0;
  logic        cmdTx = 1'b0;
  logic [4:0]  cmdSubaddr = '0;
  logic [4:0]  cmdCount = '0;
  logic        msgEnd = 1'b0;
  logic        legalIn = 1'b1;
  logic        busyInN = 1'b1;
  logic [4:0]  rtAddr = '0;
  logic [11:0] tableAddr;
  logic        respValid;
  logic [15:0] statusWord;
  logic [5:0]  txWordCount;
  logic        rxPass;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_legality_responder #(.SAMPLE_DELAY(DELAY)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdBcast(cmdBcast),
    .cmdTx(cmdTx), .cmdSubaddr(cmdSubaddr), .cmdCount(cmdCount),
    .msgEnd(msgEnd), .legalIn(legalIn), .busyInN(busyInN), .rtAddr(rtAddr),
    .tableAddr(tableAddr), .respValid(respValid), .statusWord(statusWord),
    .txWordCount(txWordCount), .rxPass(rxPass)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkStatus(input logic [4:0] rta, input logic me, input logic bz);
    logic [15:0] s;
    s = '0;
    s[15:11] = rta;
    s[10] = me;
    s[3] = bz;
    return s;
  endfunction

  // drives a command strobe across one rising edge; returns at the next falling edge
  task automatic sendCmd(input logic bc, input logic tx, input logic [4:0] sa, input logic [4:0] wc);
    cmdBcast = bc; cmdTx = tx; cmdSubaddr = sa; cmdCount = wc;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic endMsg();
    msgEnd = 1'b1;
    @(negedge clk);
    msgEnd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 tableAddr", 32'(tableAddr), 32'h0);
    check("R11 statusWord", 32'(statusWord), 32'h0);
    check("R11 txWordCount", 32'(txWordCount), 32'h0);
    check("R11 rxPass", 32'(rxPass), 32'h0);
    check("R11 respValid", 32'(respValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      legalIn = VECS[i].legal;
      busyInN = VECS[i].busyN;
      rtAddr  = VECS[i].rta;
      sendCmd(VECS[i].bc, VECS[i].tx, VECS[i].sa, VECS[i].wc);
      check("R1 tableAddr", 32'(tableAddr),
            32'({VECS[i].bc, VECS[i].tx, VECS[i].sa, VECS[i].wc}));
      repeat (DELAY - 1) @(negedge clk);
      check("R2 respValid early", 32'(respValid), 32'h0);
      @(negedge clk);
      check("R2 respValid", 32'(respValid), 32'h1);
      check("R3 R4 R5 statusWord", 32'(statusWord),
            32'(mkStatus(VECS[i].rta, VECS[i].expMe, VECS[i].expBusy)));
      check("R6 R7 txWordCount", 32'(txWordCount), 32'(VECS[i].expCnt));
      check("R8 rxPass", 32'(rxPass), 32'(VECS[i].expRx));
      legalIn = ~VECS[i].legal;
      busyInN = ~VECS[i].busyN;
      rtAddr  = ~VECS[i].rta;
      repeat (5) @(negedge clk);
      check("R9 held statusWord", 32'(statusWord),
            32'(mkStatus(VECS[i].rta, VECS[i].expMe, VECS[i].expBusy)));
      check("R9 held txWordCount", 32'(txWordCount), 32'(VECS[i].expCnt));
      check("R1 addr stable", 32'(tableAddr),
            32'({VECS[i].bc, VECS[i].tx, VECS[i].sa, VECS[i].wc}));
      endMsg();
      check("R9 cleared statusWord", 32'(statusWord), 32'h0);
      check("R9 cleared txWordCount", 32'(txWordCount), 32'h0);
      check("R9 cleared rxPass", 32'(rxPass), 32'h0);
    end

    // R2: only the value at the sample edge counts
    legalIn = 1'b0; busyInN = 1'b0; rtAddr = 5'h05;
    sendCmd(1'b0, 1'b1, 5'd4, 5'd2);
    repeat (DELAY - 1) @(negedge clk);
    legalIn = 1'b1; busyInN = 1'b1; rtAddr = 5'h1C;
    @(negedge clk);
    legalIn = 1'b0; busyInN = 1'b0; rtAddr = 5'h05;
    check("R2 sample window status", 32'(statusWord), 32'(mkStatus(5'h1C, 1'b0, 1'b0)));
    check("R2 sample window count", 32'(txWordCount), 32'd2);
    endMsg();

    // R10: a new command restarts the delay and clears held results
    legalIn = 1'b1; busyInN = 1'b1; rtAddr = 5'h09;
    sendCmd(1'b0, 1'b1, 5'd6, 5'd3);
    repeat (DELAY) @(negedge clk);
    check("R10 first sample", 32'(txWordCount), 32'd3);
    sendCmd(1'b0, 1'b1, 5'd8, 5'd5);
    check("R10 cleared by cmd", 32'(txWordCount), 32'd0);
    repeat (3) @(negedge clk);
    sendCmd(1'b0, 1'b1, 5'd9, 5'd7);
    repeat (DELAY - 1) @(negedge clk);
    check("R10 no sample from cancelled cmd", 32'(respValid), 32'h0);
    check("R10 no status from cancelled cmd", 32'(statusWord), 32'h0);
    @(negedge clk);
    check("R10 restart sample", 32'(respValid), 32'h1);
    check("R10 restart count", 32'(txWordCount), 32'd7);
    check("R10 restart addr", 32'(tableAddr), 32'({1'b0, 1'b1, 5'd9, 5'd7}));
    endMsg();

    // R9: message end before the sample point cancels it
    sendCmd(1'b0, 1'b0, 5'd2, 5'd2);
    repeat (2) @(negedge clk);
    endMsg();
    repeat (DELAY) @(negedge clk);
    check("R9 aborted respValid", 32'(respValid), 32'h0);
    check("R9 aborted rxPass", 32'(rxPass), 32'h0);

    // R10: cmdValid wins over a simultaneous msgEnd
    msgEnd = 1'b1;
    sendCmd(1'b0, 1'b1, 5'd1, 5'd1);
    msgEnd = 1'b0;
    repeat (DELAY) @(negedge clk);
    check("R10 priority sample", 32'(respValid), 32'h1);
    check("R10 priority count", 32'(txWordCount), 32'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule